// File: doc/BRIEF.md
# Bus Cycle Strobe Decoder

This block connects a 16-bit processor to memory and I/O devices. The processor shares one bus between address and data. While the address strobe is high, the block captures the shared bus into an address register at each clock edge. The register drives the address outputs for the rest of the bus cycle.

While the active-low data strobe is asserted, the block looks at two qualifiers, memory/IO and read/write, and pulls exactly one of four active-low strobes low. The four strobes are memory read, memory write, I/O read and I/O write. The block also decodes a few fixed I/O addresses:

- An I/O write to one address produces an interrupt-acknowledge pulse.
- An I/O read of another address enables configuration readback. The five configuration pins then appear on the low bus bits.
- I/O writes to a pair of command addresses set or clear a start-up ROM flag.

A DMA master can take over the address and strobe lines. It does this with the active-low strobe-enable input together with two float-enable inputs. The block reports the result through output-enable signals, which drive the pad buffers.

Top module: `bus_strobe_decoder`

## Requirements
- R1: On each clock edge where `addr_stb` is 1, `addr_out` takes the value of `bus_in`. At every other edge it holds. Reset clears it to 0.
- R2: While `data_stb_n` is 1, all four strobes (`mem_rd_n`, `mem_wr_n`, `io_rd_n`, `io_wr_n`) are 1.
- R3: While `data_stb_n` is 0, exactly one strobe is 0, chosen by the qualifiers as follows. `mem_io`=1 and `rd_wr`=1 selects `mem_rd_n`. `mem_io`=1 and `rd_wr`=0 selects `mem_wr_n`. `mem_io`=0 and `rd_wr`=1 selects `io_rd_n`. `mem_io`=0 and `rd_wr`=0 selects `io_wr_n`.
- R4: `inta_n` is 0 exactly when `data_stb_n`=0, the cycle is an I/O write, and the latched address is 0x1000.
- R5: `cfg_en_n` is 0 exactly when `data_stb_n`=0, the cycle is an I/O read, and the latched address is 0x8410. In that phase `bus_oe`=1, `bus_out[4:0]` equals `cfg_pins`, and `bus_out[15:5]` is 0.
- R6: At all other times `bus_oe` is 0, so the bus is left undriven.
- R7: After reset, `sur_flag` is 1.
- R8: At a clock edge during an I/O write with the data strobe low, the latched address decides the flag. Address 0x4004 sets `sur_flag` to 1 and address 0x4005 clears it to 0. Memory cycles and I/O reads to these addresses leave it unchanged.
- R9: `addr_oe` is 0 when `strb_en_n`=1 and `addr_float_en`=1. Otherwise it is 1.
- R10: `strb_oe` is 0 when `strb_en_n`=1 and `strb_float_en`=1. Otherwise it is 1. `inta_n` and `cfg_en_n` are never floated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_stb | input | 1 | Address strobe, active high |
| data_stb_n | input | 1 | Data strobe, active low |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_in | input | 16 | Shared address/data bus, input side |
| cfg_pins | input | 5 | Configuration inputs |
| strb_en_n | input | 1 | Strobe enable, active low (high lets outputs float) |
| addr_float_en | input | 1 | Allows the address outputs to float |
| strb_float_en | input | 1 | Allows the four strobes to float |
| addr_out | output | 16 | Latched address |
| addr_oe | output | 1 | Address pad output enable |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| strb_oe | output | 1 | Strobe pad output enable |
| inta_n | output | 1 | Interrupt acknowledge, active low |
| cfg_en_n | output | 1 | Configuration read enable, active low |
| bus_out | output | 16 | Bus output data |
| bus_oe | output | 1 | Bus output enable |
| sur_flag | output | 1 | Start-up ROM flag |

## Verification
Some properties are checked by assertions on every cycle:

- The strobes are all idle whenever the data strobe is high.
- Exactly one strobe is low whenever the data strobe is low.
- The acknowledge and configuration strobes appear only in their own kind of I/O cycle.
- The address register captures the bus or holds it from edge to edge.
- The start-up ROM flag follows the set and clear commands.

Other behaviour can only be shown by the bench's scenarios:

- The exact decoded addresses, and that neighbouring addresses do not decode.
- The configuration value placed on the bus.
- That memory cycles and reads to the command addresses leave the flag alone.
- The float behaviour across all combinations of strobe enable and float enables.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int ADDR_W = 16;
    localparam int CFG_W  = 5;

    // Encoding is {mem_io, rd_wr}
    typedef enum logic [1:0] {
        CYC_IO_WR  = 2'b00,
        CYC_IO_RD  = 2'b01,
        CYC_MEM_WR = 2'b10,
        CYC_MEM_RD = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                          io_rd_n: 1'b1, io_wr_n: 1'b1};

    function automatic cyc_kind_e classify(input logic mem_io, input logic rd_wr);
        return cyc_kind_e'({mem_io, rd_wr});
    endfunction

    function automatic strobes_t strobe_for(input logic active, input cyc_kind_e kind);
        strobes_t s;
        s = STROBES_IDLE;
        if (active) begin
            unique case (kind)
                CYC_MEM_RD: s.mem_rd_n = 1'b0;
                CYC_MEM_WR: s.mem_wr_n = 1'b0;
                CYC_IO_RD:  s.io_rd_n  = 1'b0;
                CYC_IO_WR:  s.io_wr_n  = 1'b0;
                default:    s = STROBES_IDLE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/bsd_addr_latch.sv
module bsd_addr_latch #(
    parameter int W = bsd_pkg::ADDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (capture) addr_q <= bus_in;
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        $past(capture && !rst) |-> addr_q == $past(bus_in));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!capture && !rst) |-> $stable(addr_q));

endmodule

// File: rtl/bsd_strobe_gen.sv
module bsd_strobe_gen
    import bsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      data_act,
    input  cyc_kind_e kind,
    output strobes_t  strb
);

    always_comb strb = strobe_for(data_act, kind);

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !data_act |-> strb == STROBES_IDLE);

    p_one_hot_r3: assert property (@(posedge clk) disable iff (rst)
        data_act |-> $countones(~strb) == 1);

endmodule

// File: rtl/bsd_io_decode.sv
module bsd_io_decode
    import bsd_pkg::*;
#(
    parameter int          W            = ADDR_W,
    parameter int          CW           = CFG_W,
    parameter logic [15:0] INTA_ADDR    = 16'h1000,
    parameter logic [15:0] CFG_ADDR     = 16'h8410,
    parameter logic [15:0] SUR_ON_ADDR  = 16'h4004,
    parameter logic [15:0] SUR_OFF_ADDR = 16'h4005
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_act,
    input  cyc_kind_e     kind,
    input  logic [W-1:0]  addr,
    input  logic [CW-1:0] cfg_pins,
    output logic          inta_n,
    output logic          cfg_en_n,
    output logic [W-1:0]  bus_out,
    output logic          bus_oe,
    output logic          sur_flag
);

    logic io_wr_phase, io_rd_phase, on_hit, off_hit, cfg_hit;

    always_comb begin
        io_wr_phase = data_act && (kind == CYC_IO_WR);
        io_rd_phase = data_act && (kind == CYC_IO_RD);
        on_hit      = io_wr_phase && (addr == W'(SUR_ON_ADDR));
        off_hit     = io_wr_phase && (addr == W'(SUR_OFF_ADDR));
        cfg_hit     = io_rd_phase && (addr == W'(CFG_ADDR));
        inta_n      = !(io_wr_phase && (addr == W'(INTA_ADDR)));
        cfg_en_n    = !cfg_hit;
        bus_oe      = cfg_hit;
        bus_out     = '0;
        if (cfg_hit) bus_out[CW-1:0] = cfg_pins;
    end

    always_ff @(posedge clk) begin
        if (rst)          sur_flag <= 1'b1;
        else if (on_hit)  sur_flag <= 1'b1;
        else if (off_hit) sur_flag <= 1'b0;
    end

    p_inta_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        !inta_n |-> (data_act && kind == CYC_IO_WR));

    p_cfg_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_en_n |-> (data_act && kind == CYC_IO_RD && bus_oe));

    p_bus_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !data_act |-> !bus_oe);

    p_sur_set_r8: assert property (@(posedge clk) disable iff (rst)
        $past(on_hit && !rst) |-> sur_flag);

    p_sur_clr_r8: assert property (@(posedge clk) disable iff (rst)
        $past(off_hit && !rst) |-> !sur_flag);

    p_sur_keep_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!on_hit && !off_hit && !rst) |-> $stable(sur_flag));

endmodule

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder
    import bsd_pkg::*;
#(
    parameter int          W            = ADDR_W,
    parameter int          CW           = CFG_W,
    parameter logic [15:0] INTA_ADDR    = 16'h1000,
    parameter logic [15:0] CFG_ADDR     = 16'h8410,
    parameter logic [15:0] SUR_ON_ADDR  = 16'h4004,
    parameter logic [15:0] SUR_OFF_ADDR = 16'h4005
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_stb,
    input  logic          data_stb_n,
    input  logic          mem_io,
    input  logic          rd_wr,
    input  logic [W-1:0]  bus_in,
    input  logic [CW-1:0] cfg_pins,
    input  logic          strb_en_n,
    input  logic          addr_float_en,
    input  logic          strb_float_en,
    output logic [W-1:0]  addr_out,
    output logic          addr_oe,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          io_rd_n,
    output logic          io_wr_n,
    output logic          strb_oe,
    output logic          inta_n,
    output logic          cfg_en_n,
    output logic [W-1:0]  bus_out,
    output logic          bus_oe,
    output logic          sur_flag
);

    logic      data_act;
    cyc_kind_e kind;
    strobes_t  strb;

    always_comb begin
        data_act = !data_stb_n;
        kind     = classify(mem_io, rd_wr);
    end

    bsd_addr_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (addr_stb),
        .bus_in  (bus_in),
        .addr_q  (addr_out)
    );

    bsd_strobe_gen u_strb (
        .clk      (clk),
        .rst      (rst),
        .data_act (data_act),
        .kind     (kind),
        .strb     (strb)
    );

    bsd_io_decode #(
        .W            (W),
        .CW           (CW),
        .INTA_ADDR    (INTA_ADDR),
        .CFG_ADDR     (CFG_ADDR),
        .SUR_ON_ADDR  (SUR_ON_ADDR),
        .SUR_OFF_ADDR (SUR_OFF_ADDR)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .data_act (data_act),
        .kind     (kind),
        .addr     (addr_out),
        .cfg_pins (cfg_pins),
        .inta_n   (inta_n),
        .cfg_en_n (cfg_en_n),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .sur_flag (sur_flag)
    );

    always_comb begin
        mem_rd_n = strb.mem_rd_n;
        mem_wr_n = strb.mem_wr_n;
        io_rd_n  = strb.io_rd_n;
        io_wr_n  = strb.io_wr_n;
        addr_oe  = !(strb_en_n && addr_float_en);
        strb_oe  = !(strb_en_n && strb_float_en);
    end

    p_addr_drive_r9: assert property (@(posedge clk) disable iff (rst)
        !strb_en_n |-> addr_oe);

    p_strb_drive_r10: assert property (@(posedge clk) disable iff (rst)
        !strb_en_n |-> strb_oe);

endmodule

// File: tb/bus_strobe_decoder_tb.sv
module bus_strobe_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_stb = 1'b0;
    logic        data_stb_n = 1'b1;
    logic        mem_io = 1'b0;
    logic        rd_wr = 1'b1;
    logic [15:0] bus_in = '0;
    logic [4:0]  cfg_pins = '0;
    logic        strb_en_n = 1'b0;
    logic        addr_float_en = 1'b0;
    logic        strb_float_en = 1'b0;
    logic [15:0] addr_out, bus_out;
    logic        addr_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, strb_oe;
    logic        inta_n, cfg_en_n, bus_oe, sur_flag;

    int n_checks = 0;
    int n_errors = 0;
    logic exp_sur = 1'b1;
    bit done = 0;

    always #5 clk = ~clk;

    bus_strobe_decoder dut_i (
        .clk(clk), .rst(rst), .addr_stb(addr_stb), .data_stb_n(data_stb_n),
        .mem_io(mem_io), .rd_wr(rd_wr), .bus_in(bus_in), .cfg_pins(cfg_pins),
        .strb_en_n(strb_en_n), .addr_float_en(addr_float_en),
        .strb_float_en(strb_float_en), .addr_out(addr_out), .addr_oe(addr_oe),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .strb_oe(strb_oe), .inta_n(inta_n),
        .cfg_en_n(cfg_en_n), .bus_out(bus_out), .bus_oe(bus_oe),
        .sur_flag(sur_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected strobes {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
    function automatic logic [3:0] exp_strobes(input logic act, input logic mio, input logic rw);
        if (!act) return 4'b1111;
        case ({mio, rw})
            2'b11:   return 4'b0111;
            2'b10:   return 4'b1011;
            2'b01:   return 4'b1101;
            default: return 4'b1110;
        endcase
    endfunction

    task automatic bus_cycle(input logic [15:0] a, input logic mio, input logic rw,
                             input logic [4:0] cfg, input logic en_n,
                             input logic af, input logic sf);
        logic io_wr, io_rd;
        io_wr = !mio && !rw;
        io_rd = !mio && rw;
        @(negedge clk);
        bus_in = a; addr_stb = 1'b1;
        strb_en_n = en_n; addr_float_en = af; strb_float_en = sf;
        @(negedge clk);
        addr_stb = 1'b0; bus_in = ~a;
        mem_io = mio; rd_wr = rw; cfg_pins = cfg; data_stb_n = 1'b0;
        #1;
        chk("R1 latched address", addr_out, a);
        chk("R3 strobe select", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
            exp_strobes(1'b1, mio, rw));
        chk("R4 interrupt ack", inta_n, !(io_wr && a == 16'h1000));
        chk("R5 config enable", cfg_en_n, !(io_rd && a == 16'h8410));
        if (io_rd && a == 16'h8410) begin
            chk("R5 config data", bus_out, {11'd0, cfg});
            chk("R5 bus drive", bus_oe, 1'b1);
        end else begin
            chk("R6 bus idle in data phase", bus_oe, 1'b0);
        end
        chk("R9 address enable", addr_oe, !(en_n && af));
        chk("R10 strobe enable", strb_oe, !(en_n && sf));
        if (io_wr && a == 16'h4004) exp_sur = 1'b1;
        if (io_wr && a == 16'h4005) exp_sur = 1'b0;
        @(negedge clk);
        data_stb_n = 1'b1;
        #1;
        chk("R2 strobes idle", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'b1111);
        chk("R6 bus idle", bus_oe, 1'b0);
        chk("R4 ack idle", inta_n, 1'b1);
        chk("R1 address hold", addr_out, a);
        chk("R8 start-up ROM flag", sur_flag, exp_sur);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1754;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        bus_in = 16'hbeef; addr_stb = 1'b1;
        @(negedge clk);
        #1;
        chk("R7 flag after reset", sur_flag, 1'b1);
        chk("R1 address after reset", addr_out, 16'h0000);
        chk("R2 idle after reset", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'b1111);
        chk("R6 bus after reset", bus_oe, 1'b0);
        rst = 1'b0; addr_stb = 1'b0;

        // Directed: each kind of cycle, special addresses and neighbours
        for (int k = 0; k < 4; k++)
            bus_cycle(16'h1234, k[1], k[0], 5'h00, 1'b0, 1'b0, 1'b0);
        bus_cycle(16'h1000, 1'b0, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0); // R4 hit
        bus_cycle(16'h1000, 1'b1, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0); // R4 memory: no ack
        bus_cycle(16'h1001, 1'b0, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0); // R4 neighbour
        bus_cycle(16'h8410, 1'b0, 1'b1, 5'h15, 1'b0, 1'b0, 1'b0); // R5 hit
        bus_cycle(16'h8410, 1'b0, 1'b0, 5'h15, 1'b0, 1'b0, 1'b0); // R5 write: no read
        bus_cycle(16'h8410, 1'b1, 1'b1, 5'h0a, 1'b0, 1'b0, 1'b0); // R5 memory
        bus_cycle(16'h4005, 1'b0, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0); // R8 clear
        bus_cycle(16'h4004, 1'b1, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0); // R8 memory write ignored
        bus_cycle(16'h4004, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 1'b0); // R8 I/O read ignored
        bus_cycle(16'h4004, 1'b0, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0); // R8 set
        for (int k = 0; k < 8; k++)                              // R9 / R10 matrix
            bus_cycle(16'h0f0f, 1'b1, 1'b1, 5'h00, k[2], k[1], k[0]);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 7));
            case (pick)
                3'd0: a = 16'h1000;
                3'd1: a = 16'h8410;
                3'd2: a = 16'h4004;
                3'd3: a = 16'h4005;
                default: a = 16'($urandom);
            endcase
            bus_cycle(a, 1'($urandom), 1'($urandom), 5'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule